// File: doc/BRIEF.md
# Interrupt Redirection Controller

This block takes level-sensitive interrupt lines from downstream devices and turns each newly pending interrupt into a message write aimed at a processor. For every line, software programs two 32-bit entries. The first holds the vector and control flags. The second holds the processor destination in a compact swizzled form. Software does not reach these entries directly: it writes an index into a select register and then reads or writes a window register.

A line that rises while its entry is unmasked and its destination is nonzero sets a pending bit. The pending bit is chosen by the vector's low bits, taken modulo the line count. The block emits a message only when that pending bit goes from clear to set. Software retires an interrupt by writing a vector to the end-of-interrupt register. Messages leave through a valid/ready port that carries a 64-bit address and a 32-bit data word. When several lines need a message at once, they are queued and sent lowest line first.

Top module: `irq_redirect_ctrl`

## Requirements
- R1: After reset no message is valid, the select register reads 0, the low entry of line i reads 0x1A000 + (i+2) (mask bit 16, level bit 15, active-low bit 13, vector i+2), and every destination entry reads 0xA0FF0000.
- R2: A 64-bit access at offset 0x800 writes or reads the select register (low 32 bits). An access at offset 0x810 writes or reads the table entry chosen by select. The low entry of line i is at index 0x10+2i and its destination entry is at 0x11+2i.
- R3: Reading the window while select equals 1 returns 0x00200001: the table size of 32 in bits 31:16 and 1 in the low bits.
- R4: On a rising line whose low entry has bit 16 clear and whose destination entry is nonzero, a message can be sent whose data word is the entry's bits 5:0. A line that is masked or has a zero destination sends nothing.
- R5: A qualifying rise sets pending bit (vector mod 8). A message is produced only if that bit was clear before.
- R6: The message address is {32'hFFFFFFFF, 4'hF, e[23:16], e[31:24], 12'h000}, where e is the line's destination entry.
- R7: A falling line clears the pending bit selected by its vector, so a later qualifying rise mapping to that bit sends again.
- R8: A write to offset 0x840 takes bits 5:0 as a vector and clears pending bit i of every line i whose vector equals it. A vector with no match leaves all pending bits unchanged.
- R9: Messages for lines that become due together are sent in ascending line order. While valid is high and ready is low, address and data hold.
- R10: An access is undecoded if it goes to any other offset, reads offset 0x840, or uses the window with select of 32 or more. If hard-fail is enabled, an undecoded access raises the error output and reads as 0. If hard-fail is off, the error output stays low, reads return all ones, and writes change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 8 | Interrupt lines, high means asserted |
| hf_en | input | 1 | Hard-fail enable for undecoded accesses |
| bus_valid | input | 1 | Register access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Read data, same cycle as the strobe |
| bus_err | output | 1 | Decode error for the current access |
| msg_valid | output | 1 | Message write request |
| msg_ready | input | 1 | Receiver accepts the message |
| msg_addr | output | 64 | Destination address of the message |
| msg_data | output | 32 | Vector word of the message |

## Verification
The checks assume the message receiver obeys the handshake, and that software never rewrites a line's entry while that line is asserted or while a message for it is still queued. The stimulus meets both conditions: it reprograms entries only after every line is low and all expected messages have drained. The read-side checks also assume each register access lasts one cycle and comes with a stable address. The bench drives every access in a single clock period, with all inputs set away from the edge.

// File: rtl/irc_pkg.sv
package irc_pkg;
  localparam logic [11:0] OFS_SELECT = 12'h800;
  localparam logic [11:0] OFS_WINDOW = 12'h810;
  localparam logic [11:0] OFS_RETIRE = 12'h840;
  localparam int ENT_MASK_BIT  = 16;
  localparam int ENT_LEVEL_BIT = 15;
  localparam int ENT_POL_BIT   = 13;
  localparam int VEC_W         = 6;
  localparam int LINE_BASE     = 16;
  localparam int VEC_OFFSET    = 2;

  function automatic logic [31:0] pack_dest(input logic [31:0] a);
    return ((a & 32'h0ff00000) >> 4) | ((a & 32'h000ff000) << 12);
  endfunction

  function automatic logic [63:0] unpack_dest(input logic [31:0] e);
    logic [31:0] lo;
    lo = ((e << 4) & 32'h0ff00000) | ((e >> 12) & 32'h000ff000) | 32'hf0000000;
    return {32'hffffffff, lo};
  endfunction
endpackage

// File: rtl/irc_regfile.sv
module irc_regfile
  import irc_pkg::*;
#(
  parameter int NLINES = 8,
  parameter int ADDR_W = 12,
  parameter logic [31:0] DEF_CPU_ADDR = 32'hfffa0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hf_en,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [63:0]       bus_wdata,
  output logic [63:0]       bus_rdata,
  output logic              bus_err,
  output logic [31:0]       low_entry  [NLINES],
  output logic [31:0]       dest_entry [NLINES],
  output logic              eoi_valid,
  output logic [VEC_W-1:0]  eoi_vec
);
  localparam int TBL_DEPTH = LINE_BASE + 2 * NLINES;
  localparam int IDX_W     = $clog2(TBL_DEPTH);
  localparam logic [31:0] VERSION_WORD = {16'(TBL_DEPTH), 16'h0001};

  logic [31:0]       sel_q, sel_d;
  logic [31:0]       tbl_q [TBL_DEPTH];
  logic [31:0]       tbl_d [TBL_DEPTH];
  logic [ADDR_W-1:0] word_addr;
  logic              hit_sel, hit_win, hit_eoi, in_range, decoded, wr;
  logic [IDX_W-1:0]  win_idx;

  function automatic logic [31:0] reset_word(input int k);
    int ln;
    if (k < LINE_BASE) return 32'h0;
    ln = (k - LINE_BASE) / 2;
    if (((k - LINE_BASE) % 2) == 1) return pack_dest(DEF_CPU_ADDR);
    return (32'h1 << ENT_MASK_BIT) | (32'h1 << ENT_LEVEL_BIT) |
           (32'h1 << ENT_POL_BIT) | 32'(ln + VEC_OFFSET);
  endfunction

  assign word_addr = {bus_addr[ADDR_W-1:3], 3'b000};
  assign hit_sel   = (word_addr == ADDR_W'(OFS_SELECT));
  assign hit_win   = (word_addr == ADDR_W'(OFS_WINDOW));
  assign hit_eoi   = (word_addr == ADDR_W'(OFS_RETIRE));
  assign in_range  = (sel_q < 32'(TBL_DEPTH));
  assign win_idx   = sel_q[IDX_W-1:0];
  assign decoded   = hit_sel | (hit_win & in_range) | (hit_eoi & bus_write);
  assign wr        = bus_valid & bus_write;
  assign bus_err   = bus_valid & ~decoded & hf_en;
  assign eoi_valid = wr & hit_eoi;
  assign eoi_vec   = bus_wdata[VEC_W-1:0];

  always_comb begin
    bus_rdata = 64'h0;
    if (!decoded)           bus_rdata = hf_en ? 64'h0 : '1;
    else if (hit_sel)       bus_rdata = {32'h0, sel_q};
    else if (hit_win) begin
      if (sel_q == 32'd1)   bus_rdata = {32'h0, VERSION_WORD};
      else                  bus_rdata = {32'h0, tbl_q[win_idx]};
    end
  end

  always_comb begin
    sel_d = sel_q;
    tbl_d = tbl_q;
    if (wr && hit_sel) sel_d = bus_wdata[31:0];
    if (wr && hit_win && in_range) tbl_d[win_idx] = bus_wdata[31:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      for (int k = 0; k < TBL_DEPTH; k++) tbl_q[k] <= reset_word(k);
    end else if (wr) begin
      sel_q <= sel_d;
      tbl_q <= tbl_d;
    end
  end

  for (genvar i = 0; i < NLINES; i++) begin : g_out
    assign low_entry[i]  = tbl_q[LINE_BASE + 2 * i];
    assign dest_entry[i] = tbl_q[LINE_BASE + 2 * i + 1];
  end

  // R10: a decode error only ever appears with hard-fail on and an access present
  p_err_needs_hf_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> (hf_en && bus_valid));
endmodule

// File: rtl/irc_pending.sv
module irc_pending
  import irc_pkg::*;
#(
  parameter int NLINES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] irq_in,
  input  logic [31:0]       low_entry  [NLINES],
  input  logic [31:0]       dest_entry [NLINES],
  input  logic              eoi_valid,
  input  logic [VEC_W-1:0]  eoi_vec,
  output logic [NLINES-1:0] new_req
);
  localparam int LINE_W = $clog2(NLINES);

  logic [NLINES-1:0] irq_q, pend_q, pend_d, rise, fall, ok, hits;
  logic [LINE_W-1:0] bidx [NLINES];

  assign rise = irq_in & ~irq_q;
  assign fall = ~irq_in & irq_q;

  for (genvar i = 0; i < NLINES; i++) begin : g_line
    assign bidx[i] = low_entry[i][LINE_W-1:0];
    assign ok[i]   = ~low_entry[i][ENT_MASK_BIT] & (|dest_entry[i]);
    assign hits[i] = (low_entry[i][VEC_W-1:0] == eoi_vec);
  end

  always_comb begin
    pend_d  = pend_q;
    new_req = '0;
    for (int i = 0; i < NLINES; i++) begin
      if (rise[i]) begin
        if (ok[i]) begin
          if (!pend_d[bidx[i]]) new_req[i] = 1'b1;
          pend_d[bidx[i]] = 1'b1;
        end else begin
          pend_d[bidx[i]] = 1'b0;
        end
      end else if (fall[i]) begin
        pend_d[bidx[i]] = 1'b0;
      end
    end
    if (eoi_valid) pend_d = pend_d & ~hits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q  <= '0;
      pend_q <= '0;
    end else begin
      irq_q  <= irq_in;
      pend_q <= pend_d;
    end
  end

  // R8: after a retire write, no matching line keeps its pending bit
  p_retire_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_valid |=> ((pend_q & $past(hits)) == '0));
endmodule

// File: rtl/irc_msg_out.sv
module irc_msg_out
  import irc_pkg::*;
#(
  parameter int NLINES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] new_req,
  input  logic [31:0]       low_entry  [NLINES],
  input  logic [31:0]       dest_entry [NLINES],
  input  logic              msg_ready,
  output logic              msg_valid,
  output logic [63:0]       msg_addr,
  output logic [31:0]       msg_data
);
  localparam int LINE_W = $clog2(NLINES);

  logic [NLINES-1:0] req_q, req_d, take;
  logic [LINE_W-1:0] pick;
  logic              load, any;
  logic              v_q, v_d;
  logic [63:0]       a_q, a_d;
  logic [31:0]       d_q, d_d;

  assign any  = |req_q;
  assign load = ~v_q | msg_ready;

  always_comb begin
    pick = '0;
    for (int i = NLINES - 1; i >= 0; i--) if (req_q[i]) pick = LINE_W'(i);
    take  = (load && any) ? (NLINES'(1) << pick) : '0;
    req_d = (req_q & ~take) | new_req;
    v_d = v_q;
    a_d = a_q;
    d_d = d_q;
    if (load) begin
      v_d = any;
      if (any) begin
        a_d = unpack_dest(dest_entry[pick]);
        d_d = {26'h0, low_entry[pick][VEC_W-1:0]};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= '0;
      v_q   <= 1'b0;
      a_q   <= '0;
      d_q   <= '0;
    end else begin
      req_q <= req_d;
      v_q   <= v_d;
      if (load) begin
        a_q <= a_d;
        d_q <= d_d;
      end
    end
  end

  assign msg_valid = v_q;
  assign msg_addr  = a_q;
  assign msg_data  = d_q;

  // R9: a stalled message keeps its content
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_addr) && $stable(msg_data)));
  // R6: every message targets the all-ones upper window
  p_addr_hi_r6: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> (msg_addr[63:28] == {32'hffffffff, 4'hf}));
endmodule

// File: rtl/irq_redirect_ctrl.sv
module irq_redirect_ctrl
  import irc_pkg::*;
#(
  parameter int NLINES = 8,
  parameter int ADDR_W = 12,
  parameter logic [31:0] DEF_CPU_ADDR = 32'hfffa0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] irq_in,
  input  logic              hf_en,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [63:0]       bus_wdata,
  output logic [63:0]       bus_rdata,
  output logic              bus_err,
  output logic              msg_valid,
  input  logic              msg_ready,
  output logic [63:0]       msg_addr,
  output logic [31:0]       msg_data
);
  logic [31:0]       low_entry  [NLINES];
  logic [31:0]       dest_entry [NLINES];
  logic              eoi_valid;
  logic [VEC_W-1:0]  eoi_vec;
  logic [NLINES-1:0] new_req;

  irc_regfile #(.NLINES(NLINES), .ADDR_W(ADDR_W), .DEF_CPU_ADDR(DEF_CPU_ADDR)) u_regs (
    .clk(clk), .rst_n(rst_n), .hf_en(hf_en),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_err(bus_err),
    .low_entry(low_entry), .dest_entry(dest_entry),
    .eoi_valid(eoi_valid), .eoi_vec(eoi_vec)
  );

  irc_pending #(.NLINES(NLINES)) u_pend (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
    .low_entry(low_entry), .dest_entry(dest_entry),
    .eoi_valid(eoi_valid), .eoi_vec(eoi_vec), .new_req(new_req)
  );

  irc_msg_out #(.NLINES(NLINES)) u_msg (
    .clk(clk), .rst_n(rst_n), .new_req(new_req),
    .low_entry(low_entry), .dest_entry(dest_entry),
    .msg_ready(msg_ready), .msg_valid(msg_valid),
    .msg_addr(msg_addr), .msg_data(msg_data)
  );
endmodule

// File: tb/test_irq_redirect_ctrl.sv
module test_irq_redirect_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  irq_in;
  logic        hf_en, bus_valid, bus_write, msg_ready;
  logic [11:0] bus_addr;
  logic [63:0] bus_wdata, bus_rdata, msg_addr;
  logic        bus_err, msg_valid;
  logic [31:0] msg_data;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 0;
  bit hold_ready = 0;
  logic [7:0] lfsr = 8'h5a;

  logic [63:0] q_addr [$];
  logic [31:0] q_data [$];
  string       q_tag  [$];

  always #10 clk = ~clk;

  irq_redirect_ctrl i_irq_redirect_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .hf_en(hf_en),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_err(bus_err),
    .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_addr(msg_addr), .msg_data(msg_data)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] dest_addr(input logic [31:0] e);
    return {32'hffffffff, 4'hf, e[23:16], e[31:24], 12'h000};
  endfunction

  task automatic expect_msg(input logic [31:0] dest, input logic [5:0] vec, input string tag);
    q_addr.push_back(dest_addr(dest));
    q_data.push_back({26'h0, vec});
    q_tag.push_back(tag);
  endtask

  // ready pattern
  always @(negedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    msg_ready <= hold_ready ? 1'b0 : (lfsr[0] | lfsr[2]);
  end

  // monitor: a transfer happens at the next rising edge
  always @(negedge clk) begin
    #5;
    if (rst_n && msg_valid && msg_ready) begin
      if (q_addr.size() == 0) begin
        check(0, "R5 unexpected message", {32'h0, msg_data}, 64'h0);
      end else begin
        logic [63:0] ea;
        logic [31:0] ed;
        string t;
        ea = q_addr.pop_front();
        ed = q_data.pop_front();
        t  = q_tag.pop_front();
        check(msg_addr == ea, {t, " addr"}, msg_addr, ea);
        check(msg_data == ed, {t, " data"}, {32'h0, msg_data}, {32'h0, ed});
      end
    end
  end

  task automatic reg_write(input logic [11:0] a, input logic [63:0] d);
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_valid = 0; bus_write = 0;
  endtask

  task automatic reg_read(input logic [11:0] a, input logic [63:0] exp, input logic exp_err, input string tag);
    @(negedge clk);
    bus_valid = 1; bus_write = 0; bus_addr = a;
    #2;
    check(bus_rdata == exp, tag, bus_rdata, exp);
    check(bus_err == exp_err, {tag, " err"}, {63'h0, bus_err}, {63'h0, exp_err});
    @(posedge clk); #1;
    bus_valid = 0;
  endtask

  task automatic set_entry(input int ln, input logic [31:0] low, input logic [31:0] dst);
    reg_write(12'h800, 64'(16 + 2 * ln));
    reg_write(12'h810, {32'h0, low});
    reg_write(12'h800, 64'(17 + 2 * ln));
    reg_write(12'h810, {32'h0, dst});
  endtask

  task automatic set_irq(input logic [7:0] v);
    @(negedge clk);
    irq_in = v;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  endtask

  initial begin
    #(20 * 20000);
    check(0, "watchdog expired", 64'h0, 64'h1);
    summary();
  end

  localparam logic [31:0] DEF_DEST = 32'ha0ff0000;
  localparam logic [31:0] D1 = 32'h34567000;

  initial begin
    rst_n = 0; irq_in = 0; hf_en = 0; bus_valid = 0; bus_write = 0;
    bus_addr = 0; bus_wdata = 0; msg_ready = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #2;
    check(msg_valid == 1'b0, "R1 no message after reset", {63'h0, msg_valid}, 64'h0);
    reg_read(12'h800, 64'h0, 0, "R1 select reset");
    reg_write(12'h800, 64'h10);
    reg_read(12'h810, 64'h1a002, 0, "R1 line0 low entry");
    reg_write(12'h800, 64'h1e);
    reg_read(12'h810, 64'h1a009, 0, "R1 line7 low entry");
    reg_write(12'h800, 64'h1f);
    reg_read(12'h810, {32'h0, DEF_DEST}, 0, "R1 line7 dest entry");

    // R2 / R3
    reg_write(12'h800, 64'h12);
    reg_read(12'h800, 64'h12, 0, "R2 select readback");
    reg_write(12'h810, 64'h0000_0000_0000_a02a);
    reg_read(12'h810, 64'ha02a, 0, "R2 window readback");
    reg_write(12'h800, 64'h1);
    reg_read(12'h810, 64'h00200001, 0, "R3 version word");

    // R4 / R6: masked line 0 (default) sends nothing; line 1 sends
    set_irq(8'h01); idle(6); set_irq(8'h00); idle(3);
    set_entry(1, 32'h0000_8009, D1);
    set_entry(2, 32'h0000_000a, 32'h0);
    set_irq(8'h04); idle(6); set_irq(8'h00); idle(3);   // R4 zero destination: silent
    expect_msg(D1, 6'h09, "R4 R6 line1 message");
    set_irq(8'h02); idle(20);

    // R5 / R7: line 3 maps to same pending bit as line 1
    set_entry(3, 32'h0000_0011, DEF_DEST);
    set_irq(8'h0a); idle(10);                            // R5 bit already set: silent
    set_irq(8'h02); idle(3);                             // R7 fall clears bit 1
    expect_msg(DEF_DEST, 6'h11, "R7 resend after fall");
    set_irq(8'h0a); idle(20);
    set_irq(8'h00); idle(5);

    // R8: retire by vector match
    set_entry(4, 32'h0000_000c, DEF_DEST);
    set_entry(5, 32'h0000_0014, DEF_DEST);
    set_entry(6, 32'h0000_001c, DEF_DEST);
    set_entry(7, 32'h0000_0024, D1);
    expect_msg(DEF_DEST, 6'h0c, "R8 first line4");
    set_irq(8'h10); idle(20);
    set_irq(8'h30); idle(10);                            // R5 silent
    reg_write(12'h840, 64'h3f);                          // R8 no match
    set_irq(8'h70); idle(10);                            // still silent
    reg_write(12'h840, 64'h0c);                          // R8 clears bit 4
    expect_msg(D1, 6'h24, "R8 after retire");
    set_irq(8'hf0); idle(20);
    set_irq(8'h00); idle(5);

    // R9: simultaneous lines leave in line order
    set_entry(0, 32'h0000_0008, DEF_DEST);
    set_entry(2, 32'h0000_000a, D1);
    set_entry(5, 32'h0000_000d, DEF_DEST);
    idle(20);
    hold_ready = 1; idle(2);
    expect_msg(DEF_DEST, 6'h08, "R9 order first");
    expect_msg(D1,       6'h0a, "R9 order second");
    expect_msg(DEF_DEST, 6'h0d, "R9 order third");
    set_irq(8'h25); idle(6);
    hold_ready = 0; idle(30);
    set_irq(8'h00); idle(5);

    // R10: undecoded accesses
    reg_read(12'h900, '1, 0, "R10 unknown offset soft");
    reg_read(12'h840, '1, 0, "R10 retire read soft");
    reg_write(12'h800, 64'h30);
    reg_read(12'h810, '1, 0, "R10 select out of range soft");
    reg_write(12'h810, 64'hdead);
    reg_write(12'h800, 64'h10);
    reg_read(12'h810, 64'h8, 0, "R10 ignored write left entry");
    hf_en = 1;
    reg_read(12'h900, 64'h0, 1, "R10 unknown offset hard");
    hf_en = 0;

    idle(10);
    check(q_addr.size() == 0, "R4 expected message missing", 64'(q_addr.size()), 64'h0);
    summary();
  end
endmodule